// File: doc/BRIEF.md
# Serial Pattern Recognizer With Lockout

This block watches a single serial bit stream, one bit per rising clock edge, and raises its output for one cycle each time the three most recently sampled bits are 0, 1, 0. Detections may overlap, so a stream such as 0,1,0,1,0 produces two pulses. A second pattern, 1, 0, 0, acts as an inhibit. The first time it appears after reset, the recognizer drops into a trap state and stays silent for every later input until it is reset again.

The machine is a Moore design with seven states. The output is decoded from the state register alone, so a match shows up in the cycle after its last bit is sampled. A parameter selects between a dense three-bit state code and a seven-bit one-hot code. The behaviour at the ports is the same for both. A control path that needs a qualified "pattern seen" strobe, with the strobe turned off for good once a forbidden sequence has arrived, instantiates this block.

Top module: `seqlock_detector`

## Requirements
- R1: While `rst_i` is high at a rising edge, the machine returns to its start state and `z_o` is 0 after that edge. Reset takes priority over the value on `x_i` in the same cycle.
- R2: After a rising edge, `z_o` is 1 when the last three bits sampled since reset, oldest first, are 0, 1, 0, and 1,0,0 has not been sampled since reset. Otherwise `z_o` is 0.
- R3: Matches overlap. Once a 0,1,0 match has been made, one further 1 followed by a 0 gives another match, so 0,1,0,1,0 produces `z_o` pulses after the third and fifth bits.
- R4: Once the bits 1,0,0 have been sampled consecutively, `z_o` stays 0 for any input until the next reset.
- R5: Leading runs of 0s, or of 1s, before the first change of value do not disturb recognition. For example, 0,0,0,1,0 and 1,1,0,1,0 each give a pulse after their last bit.
- R6: `z_o` depends only on the state register. A change on `x_i` between clock edges does not change `z_o`.
- R7: After a reset that ends a lockout, recognition works again as in R2.
- R8: The parameter `STATE_ENC` (0 for a dense code, 1 for one-hot) does not change the port behaviour. Any other value is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| x_i | input | 1 | Serial data bit, sampled on each rising edge |
| z_o | output | 1 | Registered detection of 0,1,0 while not locked |

## Verification
Two functions can act at the same edge. A synchronous reset can arrive in the very cycle that would complete 0,1,0, and a clock can end a detection in the same edge that moves the machine into lockout. The bench forces the first case by raising reset together with the final 0 of a match, and expects `z_o` low after that edge. It forces the second case by following a match with a 0, and expects the pulse to end and every later pulse to be suppressed. Both encodings run side by side against a behavioural history-and-flag model on every clock.

// File: rtl/seqlock_pkg.sv
package seqlock_pkg;

   localparam int unsigned NUM_STATES = 7;
   localparam int unsigned ENC_W      = $clog2(NUM_STATES);

   typedef enum logic [ENC_W-1:0] {
      ST_IDLE = 3'd0,   // nothing sampled yet
      ST_Z    = 3'd1,   // trailing 0 (run of zeros)
      ST_ZO   = 3'd2,   // trailing 0,1
      ST_ZOZ  = 3'd3,   // trailing 0,1,0  -> output high
      ST_O    = 3'd4,   // trailing 1 (run of ones)
      ST_OZ   = 3'd5,   // trailing 1,0
      ST_LOCK = 3'd6    // inhibit pattern seen, absorbing
   } seq_state_e;

   function automatic seq_state_e step_state(input seq_state_e cur, input logic bit_in);
      seq_state_e nxt;
      unique case (cur)
         ST_IDLE: nxt = bit_in ? ST_O  : ST_Z;
         ST_Z:    nxt = bit_in ? ST_ZO : ST_Z;
         ST_ZO:   nxt = bit_in ? ST_O  : ST_ZOZ;
         ST_ZOZ:  nxt = bit_in ? ST_ZO : ST_LOCK;
         ST_O:    nxt = bit_in ? ST_O  : ST_OZ;
         ST_OZ:   nxt = bit_in ? ST_ZO : ST_LOCK;
         ST_LOCK: nxt = ST_LOCK;
         default: nxt = ST_IDLE;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/seqlock_next.sv
module seqlock_next
   import seqlock_pkg::*;
(
   input  seq_state_e cur_i,
   input  logic       x_i,
   output seq_state_e nxt_o
);
   always_comb begin
      nxt_o = step_state(cur_i, x_i);
   end
endmodule

// File: rtl/seqlock_state_reg.sv
module seqlock_state_reg
   import seqlock_pkg::*;
#(
   parameter int unsigned STATE_ENC = 0
)(
   input  logic       clk_i,
   input  logic       rst_i,
   input  seq_state_e nxt_i,
   output seq_state_e cur_o
);
   localparam int unsigned REG_W = (STATE_ENC == 1) ? NUM_STATES : ENC_W;

   if (!(STATE_ENC == 0 || STATE_ENC == 1)) begin : g_bad_enc
      $error("seqlock_state_reg: STATE_ENC must be 0 or 1");
   end

   logic [REG_W-1:0] state_q;

   if (STATE_ENC == 1) begin : g_onehot
      logic [REG_W-1:0] nxt_vec;
      always_comb begin
         nxt_vec = '0;
         nxt_vec[nxt_i] = 1'b1;
      end
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            state_q <= REG_W'(1) << ST_IDLE;
         end else begin
            state_q <= nxt_vec;
         end
      end
      always_comb begin
         cur_o = ST_IDLE;
         for (int i = 0; i < int'(REG_W); i++) begin
            if (state_q[i]) cur_o = seq_state_e'(i);
         end
      end
   end else begin : g_dense
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            state_q <= ST_IDLE;
         end else begin
            state_q <= nxt_i;
         end
      end
      assign cur_o = seq_state_e'(state_q);
   end
endmodule

// File: rtl/seqlock_out.sv
module seqlock_out
   import seqlock_pkg::*;
(
   input  seq_state_e cur_i,
   output logic       z_o,
   output logic       locked_o
);
   always_comb begin
      z_o      = (cur_i == ST_ZOZ);
      locked_o = (cur_i == ST_LOCK);
   end
endmodule

// File: rtl/seqlock_detector.sv
module seqlock_detector
   import seqlock_pkg::*;
#(
   parameter int unsigned STATE_ENC = 0
)(
   input  logic clk_i,
   input  logic rst_i,
   input  logic x_i,
   output logic z_o
);
   seq_state_e cur_st;
   seq_state_e nxt_st;
   logic       locked;

   seqlock_next u_next (
      .cur_i (cur_st),
      .x_i   (x_i),
      .nxt_o (nxt_st)
   );

   seqlock_state_reg #(.STATE_ENC(STATE_ENC)) u_reg (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .nxt_i (nxt_st),
      .cur_o (cur_st)
   );

   seqlock_out u_out (
      .cur_i    (cur_st),
      .z_o      (z_o),
      .locked_o (locked)
   );
endmodule

// File: rtl/seqlock_checker.sv
module seqlock_checker (
   input logic clk_i,
   input logic rst_i,
   input logic x_i,
   input logic z_o,
   input logic locked
);
   AST_RESET_CLEARS: assert property (@(posedge clk_i) rst_i |=> !z_o); // R1
   AST_MATCH_HISTORY: assert property (@(posedge clk_i) disable iff (rst_i)
      z_o |-> (!$past(x_i) && $past(x_i, 2) && !$past(x_i, 3))); // R2
   AST_LOCK_ENTRY: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(locked) |-> (!$past(x_i) && !$past(x_i, 2))); // R4
   AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
      locked |=> (locked && !z_o)); // R4
   AST_OVERLAP: assert property (@(posedge clk_i) disable iff (rst_i)
      (z_o && x_i) |=> (!z_o && !locked)); // R3
endmodule

bind seqlock_detector seqlock_checker u_chk (
   .clk_i  (clk_i),
   .rst_i  (rst_i),
   .x_i    (x_i),
   .z_o    (z_o),
   .locked (locked)
);

// File: tb/seqlock_detector_tb_top.sv
module seqlock_detector_tb_top;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic x   = 1'b0;
   logic z_dense, z_oh;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   // behavioural reference
   int       nbits = 0;
   bit [2:0] hist  = '0;
   bit       seen_inhibit = 0;
   bit       exp_z = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seqlock_detector #(.STATE_ENC(0)) dut_i (
      .clk_i(clk), .rst_i(rst), .x_i(x), .z_o(z_dense));
   seqlock_detector #(.STATE_ENC(1)) dut_oh_i (
      .clk_i(clk), .rst_i(rst), .x_i(x), .z_o(z_oh));

   task automatic check(input string req, input bit act, input bit exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: z actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_step(input bit r, input bit b);
      if (r) begin
         nbits = 0; hist = '0; seen_inhibit = 0; exp_z = 0;
      end else begin
         hist = {hist[1:0], b};
         nbits++;
         if (nbits >= 3 && hist == 3'b100) seen_inhibit = 1;
         exp_z = (nbits >= 3) && (hist == 3'b010) && !seen_inhibit;
      end
   endtask

   // drive one cycle, compare both encodings after the edge (R8)
   task automatic cycle(input bit r, input bit b, input string req);
      @(negedge clk);
      rst = r; x = b;
      @(posedge clk);
      model_step(r, b);
      #1;
      check({req, " dense"}, z_dense, exp_z);
      check({req, " onehot R8"}, z_oh, exp_z);
   endtask

   task automatic run_str(input string s, input string req);
      for (int i = 0; i < s.len(); i++) cycle(1'b0, s[i] == "1", req);
   endtask

   task automatic run_pair(input string xs, input string zs, input string req);
      for (int i = 0; i < xs.len(); i++) begin
         cycle(1'b0, xs[i] == "1", req);
         check({req, " table"}, z_dense, zs[i] == "1");
      end
   endtask

   initial begin
      cycle(1'b1, 1'b0, "R1");
      cycle(1'b1, 1'b1, "R1");
      // reference pairs (R2, R4)
      run_pair("00101010010", "00010101000", "R2");
      cycle(1'b1, 1'b0, "R1");
      run_pair("11011010010", "00000001000", "R4");
      // overlap R3
      cycle(1'b1, 1'b0, "R1");
      run_pair("01010", "00101", "R3");
      // leading runs R5
      cycle(1'b1, 1'b0, "R1");
      run_pair("00010", "00001", "R5");
      cycle(1'b1, 1'b0, "R1");
      run_pair("11010", "00001", "R5");
      // lockout holds for any input R4, then recovery R7
      cycle(1'b1, 1'b0, "R1");
      run_str("100010101010", "R4");
      cycle(1'b1, 1'b0, "R7");
      run_pair("010", "001", "R7");
      // reset coincident with completing bit R1
      cycle(1'b1, 1'b0, "R1");
      run_str("01", "R1");
      cycle(1'b1, 1'b0, "R1 coincident");
      // mid-cycle input change R6
      run_str("010", "R6");
      #1 x = ~x;
      #1 check("R6 dense", z_dense, exp_z);
      check("R6 onehot", z_oh, exp_z);
      // random streams with periodic reset
      for (int k = 0; k < 400; k++) begin
         cycle((k % 13) == 0, 1'($urandom), "R2 random");
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule